// File: doc/BRIEF.md
# Two-Line Bus Glitch Filter

This block cleans up the two wires of a two-wire serial bus: the data line and the clock line. Each cleaned output copies its raw input only after the input has kept the same level for a fixed run of system clocks. A change that does not last that long never reaches the output.

Each line has its own down-counter and its own previous-sample register. Any difference between the current sample and the previous one restarts the counter at its full value. Because of this, a line that keeps toggling can never pass a level through, however the toggles are spaced. A short majority or all-equal window would let such a level through.

The counter width is a parameter, `CNT_W`, and the reload value is all ones in that width. With the default `CNT_W = 3` the reload value is 7, and the latency is 9 edges. Both outputs rest high after reset, which is the idle level of the bus. Synchronisation of the raw inputs against metastability is left to the surrounding logic.

Top module: `glitch_filter_pair`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, both `sdaClean` and `sclClean` are 1 after that edge. This holds even if they were 0 before.
- R2: A raw line changes to a new level and holds it. Counting as edge 1 the first rising edge that samples the new level, the cleaned output takes that level after edge 2^CNT_W+1 (edge 9 by default) and not before.
- R3: A pulse that returns to the previous level after being sampled on at most 2^CNT_W edges (8 by default) leaves the cleaned output unchanged. This holds for both polarities.
- R4: Any change of level during the wait restarts the full interval. After a brief return to the old level, the new level appears only 2^CNT_W+1 edges after it was last re-sampled.
- R5: The two lines are filtered independently. Activity on one raw input never changes the other cleaned output.
- R6: Once a raw input has held one level for at least 2^CNT_W+1 sampling edges, its cleaned output equals that level.
- R7: A cleaned output only changes to the level its raw input had at the previous sampling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sdaRaw | input | 1 | Raw level of the data line |
| sclRaw | input | 1 | Raw level of the clock line |
| sdaClean | output | 1 | Filtered data line, registered |
| sclClean | output | 1 | Filtered clock line, registered |

## Verification
A counter that reloads at the wrong time or stops one step early shifts the edge at which a steady change appears. This shows up at the port as an output one edge early or late, within nine edges of the change. A counter that does not restart on a glitch lets a short pulse leak through. The leak is visible while the pulse is still held or just after it ends. A mix-up between the two lanes shows up as one output moving while only the other input toggles. The pulse-width sweep covers both lines and both polarities, so each of these faults shows up within one pulse.

// File: rtl/glitch_filter_pkg.sv
package glitch_filter_pkg;

  // Per-lane command from control to datapath; exactly one is set per cycle.
  typedef struct packed {
    logic reload;     // input moved: restart the stability count
    logic countDown;  // input steady, count not yet exhausted
    logic pass;       // input steady long enough: copy it to the output
  } laneStrobe_t;

endpackage

// File: rtl/gf_ctrl.sv
module gf_ctrl
  import glitch_filter_pkg::*;
#(
  parameter int NUM_LINES = 2
) (
  input  logic [NUM_LINES-1:0] rawIn,
  input  logic [NUM_LINES-1:0] prevSample,
  input  logic [NUM_LINES-1:0] cntZero,
  output laneStrobe_t [NUM_LINES-1:0] strobes
);

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLane
    logic steady;
    // Each lane compares only with its own previous sample.
    assign steady = (rawIn[g] == prevSample[g]);

    always_comb begin
      strobes[g].reload    = !steady;
      strobes[g].countDown = steady && !cntZero[g];
      strobes[g].pass      = steady && cntZero[g];
    end
  end

endmodule

// File: rtl/gf_datapath.sv
module gf_datapath
  import glitch_filter_pkg::*;
#(
  parameter int NUM_LINES = 2,
  parameter int CNT_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] rawIn,
  input  laneStrobe_t [NUM_LINES-1:0] strobes,
  output logic [NUM_LINES-1:0] prevSample,
  output logic [NUM_LINES-1:0] cntZero,
  output logic [NUM_LINES-1:0] cleanOut
);

  localparam logic [CNT_W-1:0] RELOAD = {CNT_W{1'b1}};

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLane
    logic [CNT_W-1:0] stableCnt;

    assign cntZero[g] = (stableCnt == '0);

    always_ff @(posedge clk) begin
      if (rst) begin
        prevSample[g] <= 1'b1;
        stableCnt     <= RELOAD;
        cleanOut[g]   <= 1'b1;
      end else begin
        prevSample[g] <= rawIn[g];
        if (strobes[g].reload) begin
          stableCnt <= RELOAD;
        end else if (strobes[g].countDown) begin
          stableCnt <= stableCnt - 1'b1;
        end
        if (strobes[g].pass) begin
          cleanOut[g] <= rawIn[g];
        end
      end
    end
  end

endmodule

// File: rtl/glitch_filter_pair.sv
module glitch_filter_pair
  import glitch_filter_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sdaRaw,
  input  logic sclRaw,
  output logic sdaClean,
  output logic sclClean
);

  localparam int NUM_LINES = 2;  // lane 0 = data, lane 1 = clock

  logic [NUM_LINES-1:0] rawIn;
  logic [NUM_LINES-1:0] prevSample;
  logic [NUM_LINES-1:0] cntZero;
  logic [NUM_LINES-1:0] cleanOut;
  laneStrobe_t [NUM_LINES-1:0] strobes;

  assign rawIn = {sclRaw, sdaRaw};

  gf_ctrl #(.NUM_LINES(NUM_LINES)) ctrl_i (
    .rawIn      (rawIn),
    .prevSample (prevSample),
    .cntZero    (cntZero),
    .strobes    (strobes)
  );

  gf_datapath #(.NUM_LINES(NUM_LINES), .CNT_W(CNT_W)) dp_i (
    .clk        (clk),
    .rst        (rst),
    .rawIn      (rawIn),
    .strobes    (strobes),
    .prevSample (prevSample),
    .cntZero    (cntZero),
    .cleanOut   (cleanOut)
  );

  assign sdaClean = cleanOut[0];
  assign sclClean = cleanOut[1];

endmodule

// File: rtl/glitch_filter_pair_chk.sv
module glitch_filter_pair_chk #(
  parameter int CNT_W = 3
) (
  input logic clk,
  input logic rst,
  input logic sdaRaw,
  input logic sclRaw,
  input logic sdaClean,
  input logic sclClean
);

  // Number of sampling edges a level must be held before it may pass.
  localparam logic [CNT_W:0] RUN_MAX = {1'b1, {CNT_W{1'b0}}};

  logic sdaLast, sclLast;
  logic [CNT_W:0] sdaRun, sclRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      sdaLast <= 1'b1;
      sclLast <= 1'b1;
      sdaRun  <= '0;
      sclRun  <= '0;
    end else begin
      sdaLast <= sdaRaw;
      sclLast <= sclRaw;
      if (sdaRaw != sdaLast) sdaRun <= '0;
      else if (sdaRun != RUN_MAX) sdaRun <= sdaRun + 1'b1;
      if (sclRaw != sclLast) sclRun <= '0;
      else if (sclRun != RUN_MAX) sclRun <= sclRun + 1'b1;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (sdaClean && sclClean)); // R1

  AST_SDA_NO_EARLY: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdaClean) |-> (sdaRun >= RUN_MAX)); // R3
  AST_SCL_NO_EARLY: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclClean) |-> (sclRun >= RUN_MAX)); // R3

  AST_SDA_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (sdaRun >= RUN_MAX) |-> (sdaClean == sdaLast)); // R6
  AST_SCL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (sclRun >= RUN_MAX) |-> (sclClean == sclLast)); // R6

  AST_SDA_FROM_INPUT: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdaClean) |-> (sdaClean == sdaLast)); // R7
  AST_SCL_FROM_INPUT: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclClean) |-> (sclClean == sclLast)); // R7

endmodule

bind glitch_filter_pair glitch_filter_pair_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .sdaRaw   (sdaRaw),
  .sclRaw   (sclRaw),
  .sdaClean (sdaClean),
  .sclClean (sclClean)
);

// File: tb/glitch_filter_pair_tb.sv
module glitch_filter_pair_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 3;
  localparam int LAT        = (1 << CNT_W) + 1;  // edges until a steady change passes

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sdaRaw = 1'b1;
  logic sclRaw = 1'b1;
  logic sdaClean, sclClean;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  glitch_filter_pair #(.CNT_W(CNT_W)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .sdaRaw   (sdaRaw),
    .sclRaw   (sclRaw),
    .sdaClean (sdaClean),
    .sclClean (sclClean)
  );

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setLine(input int line, input logic v);
    if (line == 0) sdaRaw = v;
    else sclRaw = v;
  endtask

  function automatic logic cleanOf(input int line);
    return (line == 0) ? sdaClean : sclClean;
  endfunction

  // Hold a level long enough to settle the output (R6).
  task automatic settle(input int line, input logic v);
    setLine(line, v);
    for (int i = 0; i < LAT + 1; i++) tick();
    check(cleanOf(line), v, "R6 settle");
  endtask

  // Pulse to !idle for `width` sampling edges, then return to idle (R2, R3, R5).
  task automatic runPulse(input int line, input logic idle, input int width);
    logic other;
    bit passes;
    other  = cleanOf(1 - line);
    passes = (width >= LAT);
    setLine(line, !idle);
    for (int i = 1; i <= width; i++) begin
      tick();
      if (passes) check(cleanOf(line), (i >= LAT) ? !idle : idle, "R2 pulse hold");
      else        check(cleanOf(line), idle, "R3 short pulse blocked");
      check(cleanOf(1 - line), other, "R5 other lane");
    end
    setLine(line, idle);
    for (int j = 1; j <= LAT + 1; j++) begin
      tick();
      if (passes) check(cleanOf(line), (j >= LAT) ? idle : !idle, "R2 return");
      else        check(cleanOf(line), idle, "R3 after short pulse");
      check(cleanOf(1 - line), other, "R5 other lane");
    end
  endtask

  // Change, glitch back for one edge after `pre` edges, then hold (R4).
  task automatic runRestart(input int line, input logic idle, input int pre);
    setLine(line, !idle);
    for (int i = 0; i < pre; i++) tick();
    setLine(line, idle);
    tick();
    setLine(line, !idle);
    for (int j = 1; j <= LAT; j++) begin
      tick();
      check(cleanOf(line), (j >= LAT) ? !idle : idle, "R4 restart after glitch");
    end
    settle(line, idle);
  endtask

  initial begin
    repeat (3) tick();
    check(sdaClean, 1'b1, "R1 reset sda");
    check(sclClean, 1'b1, "R1 reset scl");
    rst = 1'b0;
    tick();

    for (int line = 0; line < 2; line++) begin
      for (int pol = 1; pol >= 0; pol--) begin
        settle(line, logic'(pol));
        for (int w = 1; w <= LAT + 3; w++) runPulse(line, logic'(pol), w);
        for (int p = 1; p < LAT - 1; p++) runRestart(line, logic'(pol), p);
      end
      settle(line, 1'b1);
    end

    // R1 again: reset pulls low outputs back to idle.
    sdaRaw = 1'b0;
    sclRaw = 1'b0;
    for (int i = 0; i < LAT + 1; i++) tick();
    check(sdaClean, 1'b0, "R6 both low");
    check(sclClean, 1'b0, "R6 both low");
    rst = 1'b1;
    tick();
    check(sdaClean, 1'b1, "R1 reset from low sda");
    check(sclClean, 1'b1, "R1 reset from low scl");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule